// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software reach the management registers of external Ethernet PHYs over a two-wire management bus. Software first sets an enable flag and a clock divider in a control register. It then writes a single command word that selects a read or a write, names the PHY and its register, and carries the write data. The controller derives the management clock from the system clock. It serialises a clause-22 frame that starts with a preamble of ones and ends with sixteen data bits. On a read it lets go of the data line for the turnaround, so that the PHY can answer. When the frame ends, the busy flag in the command word drops by itself. For reads, the acknowledge flag and the returned data then sit in that same word.

The controller handles one command at a time. Any write to the command word is ignored while a command is in flight, so software only needs to poll the busy flag. A third register holds one link bit per PHY address. The controller refreshes that bit whenever a read of the PHY status register is acknowledged.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset the control register (address 0) reads 0x8000_0000 (idle set, enable clear, divider 0), the command register (address 1) and link register (address 2) read zero, and mdc and mdioOe are low.
- R2: While a command runs, mdc has a period of 2×(divider+1) clock cycles, where the divider is control bits 7:0. Whenever no command runs, mdc stays low.
- R3: A write command (command bit 30 = 1) sends, MSB first, 32 ones, start 01, opcode 01, PHY address (bits 20:16), register address (bits 25:21), turnaround 10 and data bits 15:0. The controller drives all 64 bits.
- R4: A read command (bit 30 = 0) sends opcode 10. The controller drives the first 46 bits and keeps mdioOe low from the first turnaround bit to the end of the frame.
- R5: The busy flag (command bit 31) reads 1 from the cycle after a command is accepted until the last bit's falling mdc edge, then clears by itself. Control bit 31 (idle) reads as its inverse.
- R6: At completion the acknowledge flag (command bit 29) is 1 after a write. After a read it is 1 exactly when mdio was sampled low on the rising mdc edge of the second turnaround bit.
- R7: After a read, command bits 15:0 hold the 16 bits sampled on the last 16 rising mdc edges, first bit in bit 15.
- R8: A write to the command register while the busy flag is 1 changes no field and starts no command, even when it lands in the completion cycle.
- R9: A command write with bit 31 set while control bit 30 (enable) is 0 is ignored entirely: no field changes and mdc stays low.
- R10: When an acknowledged read of PHY register 1 completes, link register bit p (p = PHY address) takes bit 2 of the read data. An unacknowledged read leaves the link register unchanged.
- R11: During a command, mdioOut changes only on falling mdc edges and stays constant while mdc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write address: 0 control, 1 command, 2 link (read only) |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 2 | Read address, same map |
| regRdData | output | 32 | Read data, combinational from regRdAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value when driven |
| mdioOe | output | 1 | Data line output enable |
| mdioIn | input | 1 | Data line as seen at the pin |

## Verification
Software can write the command register on the exact clock edge where the frame's last falling mdc edge clears the busy flag. The bench forces this collision. With divider 0 a frame takes 128 cycles, so the bench places a second go write on the 128th edge after acceptance. The bench then judges the result in three ways. The completed word must still carry the first command's fields. mdc must stay low with no further rising edges. The next command issued must run normally. A second write falls mid-frame at a larger divider, while the divider counter is between edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // register map
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_USER = 2'd1;
  localparam logic [1:0] ADDR_LINK = 2'd2;

  // command word fields
  localparam int GO_BIT   = 31;
  localparam int WR_BIT   = 30;
  localparam int ACK_BIT  = 29;
  localparam int REG_LSB  = 21;
  localparam int PHY_LSB  = 16;

  // control word fields
  localparam int IDLE_BIT = 31;
  localparam int EN_BIT   = 30;

  // link tracking: status register and its link bit
  localparam logic [4:0] LINK_STATUS_REG = 5'd1;
  localparam int         LINK_DATA_BIT   = 2;

  typedef struct packed {
    logic load;     // capture a new frame into the shifter
    logic shift;    // advance to the next bit (falling mdc)
    logic sample;   // capture mdioIn (rising mdc)
    logic grabAck;  // capture turnaround response
    logic drive;    // controller owns the data line
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             mdc,
  output logic             riseTick,
  output logic             fallTick
);
  logic [DIV_W-1:0] divCnt;
  logic             hit;

  assign hit      = run && (divCnt == divider);
  assign riseTick = hit && !mdc;
  assign fallTick = hit && mdc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (!run) begin
      divCnt <= '0;
      mdc    <= 1'b0;
    end else if (hit) begin
      divCnt <= '0;
      mdc    <= ~mdc;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t stb,
  input  logic         cmdWrite,
  input  logic [4:0]   cmdPhy,
  input  logic [4:0]   cmdReg,
  input  logic [15:0]  cmdData,
  input  logic         mdioIn,
  output logic         mdioOut,
  output logic         mdioOe,
  output logic [15:0]  rdData,
  output logic         ackSeen
);
  localparam int FRAME_LEN = PRE_LEN + 32;

  logic [FRAME_LEN-1:0] frame;
  logic [FRAME_LEN-1:0] outShift;
  logic [15:0]          rdShift;

  // read frames idle the line high after the address fields
  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             cmdWrite ? 2'b01 : 2'b10,
             cmdPhy, cmdReg,
             cmdWrite ? 2'b10 : 2'b11,
             cmdWrite ? cmdData : 16'hFFFF};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      rdShift  <= '0;
      ackSeen  <= 1'b0;
    end else begin
      if (stb.load) begin
        outShift <= frame;
        ackSeen  <= 1'b0;
      end else begin
        if (stb.shift)   outShift <= {outShift[FRAME_LEN-2:0], 1'b0};
        if (stb.grabAck) ackSeen  <= !mdioIn;
      end
      if (stb.sample) rdShift <= {rdShift[14:0], mdioIn};
    end
  end

  assign mdioOut = outShift[FRAME_LEN-1];
  assign mdioOe  = stb.drive;
  assign rdData  = rdShift;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regWrAddr,
  input  logic [31:0]      regWrData,
  input  logic             riseTick,
  input  logic             fallTick,
  input  logic [15:0]      rdData,
  input  logic             ackSeen,
  output logic             busy,
  output mdioStrobes_t     stb,
  output logic [DIV_W-1:0] divider,
  output logic [31:0]      ctlWord,
  output logic [31:0]      userWord,
  output logic [31:0]      linkWord
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA1_IDX  = CNT_W'(PRE_LEN + 14);
  localparam logic [CNT_W-1:0] TA2_IDX  = CNT_W'(PRE_LEN + 15);

  logic             enable;
  logic             goFlag;
  logic             wrFlag;
  logic             ackFlag;
  logic [4:0]       regAddr;
  logic [4:0]       phyAddr;
  logic [15:0]      dataField;
  logic [31:0]      linkReg;
  logic [CNT_W-1:0] bitIdx;

  logic userWrite, accept, fieldLoad, lastBit, done;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[29:26];

  assign userWrite = regWrEn && (regWrAddr == ADDR_USER) && !goFlag;
  assign accept    = userWrite && regWrData[GO_BIT] && enable;
  assign fieldLoad = userWrite && (!regWrData[GO_BIT] || enable);
  assign lastBit   = (bitIdx == LAST_IDX);
  assign done      = goFlag && fallTick && lastBit;

  always_comb begin
    stb.load    = accept;
    stb.shift   = goFlag && fallTick && !lastBit;
    stb.sample  = goFlag && riseTick;
    stb.grabAck = goFlag && riseTick && !wrFlag && (bitIdx == TA2_IDX);
    stb.drive   = goFlag && (wrFlag || (bitIdx < TA1_IDX));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      divider   <= '0;
      goFlag    <= 1'b0;
      wrFlag    <= 1'b0;
      ackFlag   <= 1'b0;
      regAddr   <= '0;
      phyAddr   <= '0;
      dataField <= '0;
      linkReg   <= '0;
      bitIdx    <= '0;
    end else begin
      if (regWrEn && (regWrAddr == ADDR_CTRL)) begin
        enable  <= regWrData[EN_BIT];
        divider <= regWrData[DIV_W-1:0];
      end
      if (fieldLoad) begin
        goFlag    <= regWrData[GO_BIT];
        wrFlag    <= regWrData[WR_BIT];
        ackFlag   <= 1'b0;
        regAddr   <= regWrData[REG_LSB+:5];
        phyAddr   <= regWrData[PHY_LSB+:5];
        dataField <= regWrData[15:0];
        bitIdx    <= '0;
      end else if (goFlag) begin
        if (stb.shift) bitIdx <= bitIdx + 1'b1;
        if (done) begin
          goFlag  <= 1'b0;
          ackFlag <= wrFlag | ackSeen;
          if (!wrFlag) dataField <= rdData;
          if (!wrFlag && ackSeen && (regAddr == LINK_STATUS_REG))
            linkReg[phyAddr] <= rdData[LINK_DATA_BIT];
        end
      end
    end
  end

  assign busy = goFlag;

  always_comb begin
    ctlWord                = '0;
    ctlWord[IDLE_BIT]      = !goFlag;
    ctlWord[EN_BIT]        = enable;
    ctlWord[DIV_W-1:0]     = divider;
    userWord               = '0;
    userWord[GO_BIT]       = goFlag;
    userWord[WR_BIT]       = wrFlag;
    userWord[ACK_BIT]      = ackFlag;
    userWord[REG_LSB+:5]   = regAddr;
    userWord[PHY_LSB+:5]   = phyAddr;
    userWord[15:0]         = dataField;
    linkWord               = linkReg;
  end
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regWrAddr,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdAddr,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t     stb;
  logic             busy;
  logic             riseTick, fallTick;
  logic [DIV_W-1:0] divider;
  logic [15:0]      rdData;
  logic             ackSeen;
  logic [31:0]      ctlWord, userWord, linkWord;

  mdio_ctrl #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .riseTick(riseTick), .fallTick(fallTick),
    .rdData(rdData), .ackSeen(ackSeen),
    .busy(busy), .stb(stb), .divider(divider),
    .ctlWord(ctlWord), .userWord(userWord), .linkWord(linkWord)
  );

  mdio_dp #(.PRE_LEN(PRE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdWrite(regWrData[WR_BIT]),
    .cmdPhy(regWrData[PHY_LSB+:5]),
    .cmdReg(regWrData[REG_LSB+:5]),
    .cmdData(regWrData[15:0]),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .rdData(rdData), .ackSeen(ackSeen)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rstN(rstN), .run(busy), .divider(divider),
    .mdc(mdc), .riseTick(riseTick), .fallTick(fallTick)
  );

  always_comb begin
    case (regRdAddr)
      ADDR_CTRL: regRdData = ctlWord;
      ADDR_USER: regRdData = userWord;
      ADDR_LINK: regRdData = linkWord;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        regWrEn,
  input logic [1:0]  regWrAddr,
  input logic        wrGo,
  input logic        enFlag,
  input logic [10:0] userFields
);
  assert_mdc_low_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  assert_release_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && regWrAddr == ADDR_USER) |=> $stable(userFields));

  assert_start_enabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && enFlag && regWrEn && regWrAddr == ADDR_USER && wrGo) |=> busy);

  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enFlag) |=> !busy);

  assert_data_on_fall_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdioOut));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr),
  .wrGo(regWrData[31]), .enFlag(ctlWord[30]),
  .userFields({userWord[30], userWord[25:16]})
);

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  rdSel = ADDR_USER;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  always #2.5 clk = ~clk;

  mdio_mgmt u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(rdSel), .regRdData(regRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // PHY model
  bit          phyRead = 0, phyAckEn = 0, phyDrive = 0, phyVal = 1;
  logic [15:0] phyData = '0;
  int          riseCnt = 0;
  logic [63:0] capFrame = '0, capOe = '0;
  logic        lastSampled = 1'b0;
  int          glitchCnt = 0;
  realtime     lastRise = 0, mdcPeriod = 0;

  assign mdioIn = mdioOe ? mdioOut : (phyDrive ? phyVal : 1'b1);

  always @(posedge mdc) begin
    capFrame    = {capFrame[62:0], mdioOut};
    capOe       = {capOe[62:0], mdioOe};
    riseCnt     = riseCnt + 1;
    mdcPeriod   = $realtime - lastRise;
    lastRise    = $realtime;
    lastSampled = mdioOut;
  end

  always @(negedge mdc) begin
    if (phyRead && phyAckEn && riseCnt >= 47 && riseCnt <= 63) begin
      phyDrive = 1;
      phyVal   = (riseCnt == 47) ? 1'b0 : phyData[63-riseCnt];
    end else begin
      phyDrive = 0;
    end
  end

  always @(negedge clk) if (mdc && mdioOut !== lastSampled) glitchCnt++;

  // scoreboard
  typedef struct {
    logic [31:0] word;
    logic [63:0] frame;
    logic [63:0] oe;
  } exp_t;
  exp_t sbq[$];
  logic prevGo = 1'b0;

  function automatic exp_t mkExp(bit wr, logic [4:0] phy, logic [4:0] rg,
                                 logic [15:0] d, bit ack, logic [15:0] pd);
    exp_t e;
    bit ackE;
    logic [15:0] dE;
    e.frame = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
               wr ? 2'b10 : 2'b11, wr ? d : 16'hFFFF};
    e.oe    = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
    ackE    = wr ? 1'b1 : ack;
    dE      = wr ? d : (ack ? pd : 16'hFFFF);
    e.word  = {1'b0, wr, ackE, 3'b000, rg, phy, dE};
    return e;
  endfunction

  always @(negedge clk) begin : monitor
    exp_t e;
    if (rstN && rdSel == ADDR_USER) begin
      if (prevGo && !regRdData[31]) begin
        if (sbq.size() == 0) chk("R5 completion with no pending command", 1, 0);
        else begin
          e = sbq.pop_front();
          chk("R6/R7 completed command word", regRdData, e.word);
          chk("R3/R4 frame bits on rising mdc", capFrame, e.frame);
          chk("R4 drive mask per bit", capOe, e.oe);
        end
      end
      prevGo = regRdData[31];
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regWrAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] v);
    rdSel = a;
    #1;
    v = regRdData;
    rdSel = ADDR_USER;
  endtask

  task automatic waitIdle();
    rdSel = ADDR_USER;
    @(negedge clk);
    while (regRdData[31]) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input bit ack, input logic [15:0] pd);
    waitIdle();
    phyRead = !wr; phyAckEn = ack; phyData = pd; riseCnt = 0;
    sbq.push_back(mkExp(wr, phy, rg, d, ack, pd));
    wreg(ADDR_USER, {1'b1, wr, 1'b0, 3'b000, rg, phy, d});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rreg(ADDR_CTRL, v); chk("R1 control reset", v, 32'h8000_0000);
    rreg(ADDR_USER, v); chk("R1 command reset", v, 32'h0);
    rreg(ADDR_LINK, v); chk("R1 link reset", v, 32'h0);
    chk("R1 mdc low", mdc, 0);
    chk("R1 oe low", mdioOe, 0);

    // R9 go while disabled
    wreg(ADDR_USER, 32'hC0A5_1111);
    repeat (20) @(negedge clk);
    rreg(ADDR_USER, v); chk("R9 disabled go ignored", v, 32'h0);
    chk("R9 no mdc edges while disabled", riseCnt, 0);

    // enable, divider 0
    wreg(ADDR_CTRL, 32'h4000_0000);
    issue(1, 5'd5, 5'd3, 16'hA5C3, 0, 16'h0);
    issue(0, 5'd9, 5'd2, 16'h0, 1, 16'h1234);
    issue(0, 5'd3, 5'd7, 16'h0, 0, 16'h5555);
    waitIdle();

    // divider 2, mid-frame observations
    wreg(ADDR_CTRL, 32'h4000_0002);
    issue(1, 5'd17, 5'd30, 16'h0F0F, 0, 16'h0);
    repeat (40) @(negedge clk);
    rreg(ADDR_CTRL, v); chk("R5 idle clear while busy", v[31], 0);
    rreg(ADDR_USER, v); chk("R5 go set while busy", v[31], 1);
    chk("R2 mdc period 2x(div+1)", 64'(int'(mdcPeriod)), 64'd30);
    wreg(ADDR_USER, 32'hC021_FFFF);
    waitIdle();
    rreg(ADDR_USER, v); chk("R8 fields kept after busy write", v[25:16], {5'd30, 5'd17});
    chk("R2 mdc low when idle", mdc, 0);

    // completion-cycle collision, divider 0
    wreg(ADDR_CTRL, 32'h4000_0000);
    waitIdle();
    phyRead = 0; phyAckEn = 0; riseCnt = 0;
    sbq.push_back(mkExp(1, 5'd2, 5'd4, 16'h00FF, 0, 16'h0));
    regWrEn = 1; regWrAddr = ADDR_USER; regWrData = {1'b1, 1'b1, 1'b0, 3'b000, 5'd4, 5'd2, 16'h00FF};
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0;
    repeat (127) @(posedge clk);
    @(negedge clk);
    regWrEn = 1; regWrData = {1'b1, 1'b0, 1'b0, 3'b000, 5'd9, 5'd9, 16'h0};
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0;
    repeat (10) @(negedge clk);
    rreg(ADDR_USER, v);
    chk("R8 no restart from completion-cycle write", v[31], 0);
    chk("R8 fields kept at completion cycle", v[25:16], {5'd4, 5'd2});
    chk("R8 no extra mdc edges", riseCnt, 64);

    // R10 link tracking
    issue(0, 5'd4, 5'd1, 16'h0, 1, 16'h0004);
    waitIdle();
    rreg(ADDR_LINK, v); chk("R10 link bit set", v, 32'h0000_0010);
    issue(0, 5'd4, 5'd1, 16'h0, 0, 16'h0);
    waitIdle();
    rreg(ADDR_LINK, v); chk("R10 unacked read keeps link", v, 32'h0000_0010);
    issue(0, 5'd4, 5'd2, 16'h0, 1, 16'h0000);
    waitIdle();
    rreg(ADDR_LINK, v); chk("R10 other register ignored", v, 32'h0000_0010);
    issue(0, 5'd4, 5'd1, 16'h0, 1, 16'hFFFB);
    waitIdle();
    rreg(ADDR_LINK, v); chk("R10 link bit cleared", v, 32'h0);

    chk("R11 mdio stable while mdc high", glitchCnt, 0);
    chk("R5 all commands completed", sbq.size(), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule